// File: doc/BRIEF.md
# Configurable Programmable Logic Cell

This block is one tile of a programmable logic fabric. A 16-entry truth table is indexed by four logic inputs and gives a combinational result. One storage bit can capture that result. A select stage chooses whether the cell's main output shows the direct result or the stored one. A dedicated carry input and carry output connect the cell straight to its neighbour, so that a column of cells forms a ripple adder without going through general routing.

The function and the mode bits are loaded serially while the configuration enable is high. Truth-table entry 0 goes in first and the five mode bits follow it. While configuration is running, the storage bit is held cleared. After the enable falls, the cell evaluates its inputs. The first active clock edge then loads the storage bit. Loading a new table changes the function the cell implements, and the hardware stays the same.

Top module: `prog_logic_cell`

## Requirements
- R1: Configuration is 21 serial bits on `cfgBit`, and one bit is taken on each rising `clk` edge while `cfgEn` is high. The first bit is table entry 0 and the sixteenth is entry 15. After these come the mode bits in this order: edge select (1 = falling edge), control style (1 = synchronous), bypass (1 = direct result on `cellOut`), arithmetic enable, and set priority. While `cfgEn` is low the configuration does not change.
- R2: With arithmetic mode off, `combOut` equals the table entry addressed by `lutIn`, with `lutIn[0]` as the least significant address bit.
- R3: Reloading the table changes the implemented function. Four different tables each give their own function over all 16 addresses.
- R4: `regOut` takes the value of `combOut` at the rising `clk` edge when edge select is 0, and at the falling edge when it is 1. It does not change at the other edge.
- R5: With control style 0, `clrIn` forces `regOut` to 0 and `setIn` forces it to 1 at once, without waiting for a clock edge.
- R6: With control style 1, `clrIn` and `setIn` take effect only at the next active clock edge.
- R7: When `setIn` and `clrIn` are both high, clear wins if set priority is 0, and set wins if it is 1.
- R8: `cellOut` equals `combOut` when bypass is 1, and equals `regOut` when bypass is 0.
- R9: With arithmetic mode on, `combOut` is `lutIn[0]` XOR `lutIn[1]` XOR `carryIn`, and `carryOut` is the majority of the same three bits.
- R10: With arithmetic mode off, `carryOut` equals `carryIn`.
- R11: While `cfgEn` is high, `regOut` is held at 0. Driving `rstN` low clears the table, the mode bits and `regOut`.
- R12: Four cells in arithmetic mode, each taking carry from the one below, add two 4-bit operands and a carry input correctly for every combination of those inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for configuration and the storage bit |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgEn | input | 1 | Configuration load enable |
| cfgBit | input | 1 | Serial configuration data |
| lutIn | input | LUT_INPUTS | Logic inputs, used as the table address |
| carryIn | input | 1 | Carry from the neighbouring cell |
| setIn | input | 1 | Set control for the storage bit |
| clrIn | input | 1 | Clear control for the storage bit |
| combOut | output | 1 | Direct table or sum result |
| regOut | output | 1 | Stored bit |
| cellOut | output | 1 | Selected output, direct or stored |
| carryOut | output | 1 | Carry to the neighbouring cell |

## Verification
The assertions assume several things about the inputs. The mode bits change only while `cfgEn` is high. `setIn` and `clrIn` never change in the same instant as an active clock edge. The active edge itself moves only during configuration, when the storage bit is held cleared. The stimulus follows these rules by driving every input one nanosecond after a rising edge, or after a falling edge when the falling edge is the active one. It also keeps `setIn` and `clrIn` low while configuration is loading.

// File: rtl/plc_pkg.sv
package plc_pkg;
  localparam int MODE_BITS  = 5;
  localparam int MODE_EDGE  = 0;
  localparam int MODE_SYNC  = 1;
  localparam int MODE_BYP   = 2;
  localparam int MODE_ARITH = 3;
  localparam int MODE_SPRI  = 4;

  typedef struct packed {
    logic edgeFall;
    logic syncCtl;
    logic bypass;
    logic arith;
    logic holdClr;
    logic clrHit;
    logic setHit;
  } cellCtrl_t;
endpackage

// File: rtl/plc_cfg_ctrl.sv
module plc_cfg_ctrl
  import plc_pkg::*;
#(
  parameter int TABLE_BITS = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cfgEn,
  input  logic                  cfgBit,
  input  logic                  setIn,
  input  logic                  clrIn,
  output logic [TABLE_BITS-1:0] truthTable,
  output cellCtrl_t             ctrl
);
  localparam int CFG_LEN = TABLE_BITS + MODE_BITS;

  logic [CFG_LEN-1:0]   shiftReg;
  logic [MODE_BITS-1:0] modeBits;

  // the oldest bit moves down to index 0, so table entry 0 ends at bit 0
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      shiftReg <= '0;
    else if (cfgEn) shiftReg <= {cfgBit, shiftReg[CFG_LEN-1:1]};
  end

  assign truthTable = shiftReg[TABLE_BITS-1:0];
  assign modeBits   = shiftReg[CFG_LEN-1:TABLE_BITS];

  logic setPri;
  assign setPri = modeBits[MODE_SPRI];

  always_comb begin
    ctrl          = '0;
    ctrl.edgeFall = modeBits[MODE_EDGE];
    ctrl.syncCtl  = modeBits[MODE_SYNC];
    ctrl.bypass   = modeBits[MODE_BYP];
    ctrl.arith    = modeBits[MODE_ARITH];
    ctrl.holdClr  = cfgEn;
    ctrl.clrHit   = clrIn & (~setIn | ~setPri);
    ctrl.setHit   = setIn & (~clrIn | setPri);
  end

  // R1: a bit is taken while enabled
  assert_shift_in_R1: assert property (@(posedge clk) disable iff (!rstN)
    cfgEn |=> shiftReg[CFG_LEN-1] == $past(cfgBit));

  // R1: the configuration holds while not enabled
  assert_cfg_stable_R1: assert property (@(posedge clk) disable iff (!rstN)
    !cfgEn |=> $stable(shiftReg));
endmodule

// File: rtl/plc_datapath.sv
module plc_datapath
  import plc_pkg::*;
#(
  parameter int LUT_INPUTS = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [(1<<LUT_INPUTS)-1:0] truthTable,
  input  cellCtrl_t                ctrl,
  input  logic [LUT_INPUTS-1:0]    lutIn,
  input  logic                     carryIn,
  output logic                     combOut,
  output logic                     regOut,
  output logic                     cellOut,
  output logic                     carryOut
);
  logic lutBit;
  logic sumBit;
  logic majBit;

  assign lutBit = truthTable[lutIn];

  generate
    if (LUT_INPUTS >= 2) begin : g_arith2
      assign sumBit = lutIn[0] ^ lutIn[1] ^ carryIn;
      assign majBit = (lutIn[0] & lutIn[1]) | (carryIn & (lutIn[0] ^ lutIn[1]));
    end else begin : g_arith1
      assign sumBit = lutIn[0] ^ carryIn;
      assign majBit = lutIn[0] & carryIn;
    end
  endgenerate

  assign combOut  = ctrl.arith ? sumBit : lutBit;
  assign carryOut = ctrl.arith ? majBit : carryIn;

  logic effClk;
  logic aClr;
  logic aSet;
  logic regQ;

  assign effClk = clk ^ ctrl.edgeFall;
  assign aClr   = ~rstN | ctrl.holdClr | (~ctrl.syncCtl & ctrl.clrHit);
  assign aSet   = ~ctrl.syncCtl & ctrl.setHit & ~aClr;

  always_ff @(posedge effClk or posedge aClr or posedge aSet) begin
    if (aClr)                              regQ <= 1'b0;
    else if (aSet)                         regQ <= 1'b1;
    else if (ctrl.syncCtl && ctrl.clrHit)  regQ <= 1'b0;
    else if (ctrl.syncCtl && ctrl.setHit)  regQ <= 1'b1;
    else                                   regQ <= combOut;
  end

  assign regOut  = regQ;
  assign cellOut = ctrl.bypass ? combOut : regQ;

  // R11: the stored bit stays cleared through configuration
  assert_hold_clear_R11: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.holdClr |-> !regQ);

  // R5: an asynchronous clear keeps the stored bit at zero
  assert_async_clr_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.syncCtl && ctrl.clrHit) |-> !regQ);

  // R5: an asynchronous set keeps the stored bit at one
  assert_async_set_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.syncCtl && ctrl.setHit && !ctrl.holdClr) |-> regQ);

  // R6: a synchronous clear lands at the active edge
  assert_sync_clr_R6: assert property (@(posedge effClk) disable iff (!rstN || ctrl.holdClr)
    (ctrl.syncCtl && ctrl.clrHit) |=> !regQ);
endmodule

// File: rtl/prog_logic_cell.sv
module prog_logic_cell
  import plc_pkg::*;
#(
  parameter int LUT_INPUTS = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cfgEn,
  input  logic                  cfgBit,
  input  logic [LUT_INPUTS-1:0] lutIn,
  input  logic                  carryIn,
  input  logic                  setIn,
  input  logic                  clrIn,
  output logic                  combOut,
  output logic                  regOut,
  output logic                  cellOut,
  output logic                  carryOut
);
  localparam int TABLE_BITS = 1 << LUT_INPUTS;

  logic [TABLE_BITS-1:0] truthTable;
  cellCtrl_t             ctrl;

  plc_cfg_ctrl #(.TABLE_BITS(TABLE_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgEn(cfgEn), .cfgBit(cfgBit),
    .setIn(setIn), .clrIn(clrIn), .truthTable(truthTable), .ctrl(ctrl)
  );

  plc_datapath #(.LUT_INPUTS(LUT_INPUTS)) u_dp (
    .clk(clk), .rstN(rstN), .truthTable(truthTable), .ctrl(ctrl),
    .lutIn(lutIn), .carryIn(carryIn), .combOut(combOut), .regOut(regOut),
    .cellOut(cellOut), .carryOut(carryOut)
  );
endmodule

// File: tb/prog_logic_cell_bench.sv
module prog_logic_cell_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgEn = 1'b0;
  logic cfgBit = 1'b0;
  logic [3:0] lutIn = '0;
  logic carryIn = 1'b0;
  logic setIn = 1'b0;
  logic clrIn = 1'b0;
  logic combOut, regOut, cellOut, carryOut;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  prog_logic_cell u_prog_logic_cell (
    .clk(clk), .rstN(rstN), .cfgEn(cfgEn), .cfgBit(cfgBit), .lutIn(lutIn),
    .carryIn(carryIn), .setIn(setIn), .clrIn(clrIn), .combOut(combOut),
    .regOut(regOut), .cellOut(cellOut), .carryOut(carryOut)
  );

  // four-cell ripple chain that shares the configuration lines
  logic [3:0] opA = '0;
  logic [3:0] opB = '0;
  logic       chainCin = 1'b0;
  logic [3:0] chainSum, chainReg, chainSel, chainCarry;

  for (genvar k = 0; k < 4; k++) begin : g_chain
    logic cIn;
    if (k == 0) begin : g_first
      assign cIn = chainCin;
    end else begin : g_next
      assign cIn = chainCarry[k-1];
    end
    prog_logic_cell u_cell (
      .clk(clk), .rstN(rstN), .cfgEn(cfgEn), .cfgBit(cfgBit),
      .lutIn({2'b00, opB[k], opA[k]}), .carryIn(cIn), .setIn(1'b0), .clrIn(1'b0),
      .combOut(chainSum[k]), .regOut(chainReg[k]), .cellOut(chainSel[k]),
      .carryOut(chainCarry[k])
    );
  end

  // function id in the top two bits, truth table in the low sixteen
  localparam logic [17:0] VECS [4] = '{
    {2'd0, 16'h8000}, {2'd1, 16'h6996}, {2'd2, 16'hE880}, {2'd3, 16'hFFFF}
  };

  function automatic logic refFn(input logic [1:0] id, input logic [3:0] a);
    case (id)
      2'd0:    return &a;
      2'd1:    return ^a;
      2'd2:    return $countones(a) >= 3;
      default: return 1'b1;
    endcase
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic loadCfg(input logic [15:0] tbl, input logic edgeF, input logic syncC,
                         input logic byp, input logic ar, input logic sPri);
    logic [20:0] bits;
    bits = {sPri, ar, byp, syncC, edgeF, tbl};
    cfgEn = 1'b1;
    for (int i = 0; i < 21; i++) begin
      cfgBit = bits[i];
      @(posedge clk); #1;
    end
    chk("R11 held during config", regOut, 1'b0);
    cfgEn = 1'b0;
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R11 reset state
    repeat (2) @(posedge clk);
    #1;
    chk("R11 reset regOut", regOut, 1'b0);
    chk("R11 reset table", combOut, 1'b0);
    chk("R10 reset carry pass", carryOut, 1'b0);
    rstN = 1'b1;
    @(posedge clk); #1;

    // R2 R3 R4 R8: table walk
    for (int v = 0; v < 4; v++) begin
      loadCfg(VECS[v][15:0], 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      for (int a = 0; a < 16; a++) begin
        lutIn = a[3:0];
        #1;
        chk(v == 0 ? "R2 lookup" : "R3 reloaded lookup", combOut, refFn(VECS[v][17:16], a[3:0]));
        @(posedge clk); #1;
        chk("R4 rising capture", regOut, refFn(VECS[v][17:16], a[3:0]));
        chk("R8 registered select", cellOut, regOut);
      end
    end

    // R1: no shifting while disabled
    loadCfg(16'h8000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 30; i++) begin
      cfgBit = i[0];
      @(posedge clk); #1;
    end
    lutIn = 4'hF; #1;
    chk("R1 table kept", combOut, 1'b1);
    lutIn = 4'h7; #1;
    chk("R1 table kept", combOut, 1'b0);

    // R4: falling edge capture
    loadCfg(16'h8000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    lutIn = 4'hF; #2;
    chk("R4 before falling edge", regOut, 1'b0);
    @(negedge clk); #1;
    chk("R4 falling capture", regOut, 1'b1);
    lutIn = 4'h0;
    @(posedge clk); #1;
    chk("R4 no rising capture", regOut, 1'b1);
    @(negedge clk); #1;
    chk("R4 falling capture", regOut, 1'b0);

    // R5 asynchronous clear and set
    loadCfg(16'hFFFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    @(posedge clk); #1;
    chk("R5 setup", regOut, 1'b1);
    clrIn = 1'b1; #1;
    chk("R5 async clear", regOut, 1'b0);
    @(posedge clk); #1;
    chk("R5 clear held", regOut, 1'b0);
    clrIn = 1'b0;
    @(posedge clk); #1;
    chk("R5 release", regOut, 1'b1);
    loadCfg(16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    @(posedge clk); #1;
    setIn = 1'b1; #1;
    chk("R5 async set", regOut, 1'b1);
    setIn = 1'b0;
    @(posedge clk); #1;
    chk("R5 set release", regOut, 1'b0);

    // R6 synchronous clear and set
    loadCfg(16'hFFFF, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    @(posedge clk); #1;
    clrIn = 1'b1; #1;
    chk("R6 clear waits", regOut, 1'b1);
    @(posedge clk); #1;
    chk("R6 clear at edge", regOut, 1'b0);
    clrIn = 1'b0;
    @(posedge clk); #1;
    chk("R6 release", regOut, 1'b1);
    loadCfg(16'h0000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    @(posedge clk); #1;
    setIn = 1'b1; #1;
    chk("R6 set waits", regOut, 1'b0);
    @(posedge clk); #1;
    chk("R6 set at edge", regOut, 1'b1);
    setIn = 1'b0;

    // R7 priority
    loadCfg(16'hFFFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    @(posedge clk); #1;
    setIn = 1'b1; clrIn = 1'b1; #1;
    chk("R7 clear wins", regOut, 1'b0);
    setIn = 1'b0; clrIn = 1'b0;
    loadCfg(16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    @(posedge clk); #1;
    setIn = 1'b1; clrIn = 1'b1; #1;
    chk("R7 set wins", regOut, 1'b1);
    setIn = 1'b0; clrIn = 1'b0;

    // R8 bypass
    loadCfg(16'h8000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    lutIn = 4'hF; #1;
    chk("R8 bypass direct", cellOut, 1'b1);
    chk("R8 stored not yet", regOut, 1'b0);

    // R10 carry pass-through with arithmetic off
    carryIn = 1'b1; #1;
    chk("R10 carry pass", carryOut, 1'b1);
    carryIn = 1'b0; #1;
    chk("R10 carry pass", carryOut, 1'b0);

    // R9 arithmetic in one cell, R12 chain
    loadCfg(16'h0000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    for (int c = 0; c < 8; c++) begin
      lutIn = {2'b11, c[1], c[0]};
      carryIn = c[2];
      #1;
      chk("R9 sum", combOut, c[0] ^ c[1] ^ c[2]);
      chk("R9 carry", carryOut, $countones(c[2:0]) >= 2);
    end
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        for (int ci = 0; ci < 2; ci++) begin
          int exp;
          opA = a[3:0]; opB = b[3:0]; chainCin = ci[0];
          #1;
          exp = a + b + ci;
          checks++;
          if ({chainCarry[3], chainSum} !== exp[4:0]) begin
            failures++;
            $display("FAIL R12 add actual=%0d expected=%0d", {chainCarry[3], chainSum}, exp[4:0]);
          end
        end
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule